// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the mode state machine of a CAN physical-layer transceiver. Two host control levels select the working mode: an awake level and a select level, both already synchronized to the block clock. The block also watches the supplies. A battery-low level takes it to Power-off. Two raw comparator levels, one for the core supply and one for the I/O supply, are filtered over time into undervoltage flags. When either flag is set, the controller forces Sleep.

Sleep is reached in one of two ways. The host can ask for it through a go-to-sleep request that must be held for a set time. Otherwise a supply fault forces it. The controller records which of the two happened, because that decides whether supply recovery alone brings the block back to Standby. A wake flag from the wake detector takes the block out of Sleep, and so does a rising edge on the awake level. All durations are counted in ticks of an external 1 MHz timebase. The outputs are the mode code, the regulator-inhibit enable, a power-on flag, a strobe that clears the wake flag, and a status bit that tells whether Silent was entered from Normal.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: Mode codes are Off=0, Standby=1, Normal=2, Silent=3, GoSleep=4 and Sleep=5. In Standby, Normal, Silent or GoSleep, with no undervoltage flag set, the mode one clock later follows the host levels (awake,select): (1,1) gives Normal, (1,0) gives Silent, (0,0) gives Standby and (0,1) gives GoSleep.
- R2: Synchronous active-high reset gives mode Off, with the inhibit enable and the power-on flag low. When battery-low is high, the mode is Off on the next clock from any mode, whatever the other inputs are. All internal state is cleared at the same time.
- R3: In Off with battery-low clear, the next clock enters Standby and sets the power-on flag.
- R4: GoSleep moves to Sleep one clock after HOLD_TICKS ticks have been counted in GoSleep with the request unchanged. If the request changes before then, the mode follows the new request instead.
- R5: While the wake flag input is high, GoSleep never moves to Sleep.
- R6: A supply flag sets on the tick that completes DET_TICKS consecutive ticks with that supply low. A good tick restarts the count. A set flag moves any active mode to Sleep one clock later.
- R7: Sleep that was forced by a supply flag is left for Standby one clock after both flags have cleared. A flag clears after REC_TICKS consecutive good ticks.
- R8: Sleep that was entered through GoSleep stays in Sleep when supply flags set and later clear.
- R9: In Sleep, a high wake flag input moves the block to Standby on the next clock.
- R10: In Sleep, a rising edge of the awake level with the I/O flag clear moves the block to Normal if select is high and to Silent if select is low. With the I/O flag set, the edge causes no mode change.
- R11: The inhibit enable is high in every mode except Off and Sleep.
- R12: The wake-clear strobe is high for one clock in the first cycle of Normal. It is also high in the cycle in which a supply flag sets. The power-on flag clears on entry to Normal.
- R13: The Silent-origin bit is high only in Silent, and only when Silent was entered directly from Normal.
- R14: A rising edge of the wake flag input clears both supply flags and restarts their counts. A power-up does the same, and so does an awake-level rising edge in Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse per timebase period (1 µs) |
| ctl_awake | input | 1 | Host awake level (low asks for a low-power mode) |
| ctl_sel | input | 1 | Host select level |
| batt_low | input | 1 | Battery undervoltage level |
| core_low | input | 1 | Raw core-supply low comparator level |
| io_low | input | 1 | Raw I/O-supply low comparator level |
| wake_seen | input | 1 | Wake flag from the wake detector |
| mode | output | 3 | Current mode code |
| inh_on | output | 1 | Enable for the external regulator switch |
| por_flag | output | 1 | Power-on flag |
| wake_clr | output | 1 | Strobe that clears the wake flag |
| silent_from_norm | output | 1 | Silent was entered from Normal |

## Verification
A supply filter whose count is off by one shows up at the ports as a forced Sleep one timebase tick too early or too late, so the bench samples on both sides of the exact tick. A wrong record of how Sleep was entered shows up only after a supply recovers, as a Standby that should not happen or a Sleep that never ends. A stale edge or hold register shows up as a GoSleep that either never completes or completes at the wrong time. Mode decoding errors appear one clock after any change in the host levels.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [2:0] {
        M_OFF    = 3'd0,
        M_STBY   = 3'd1,
        M_NORM   = 3'd2,
        M_SILENT = 3'd3,
        M_GTS    = 3'd4,
        M_SLEEP  = 3'd5
    } mode_e;

    localparam int NUM_SUPPLY = 2;
    localparam int SUP_CORE   = 0;
    localparam int SUP_IO     = 1;

    // Host level pair to requested active mode.
    function automatic mode_e pin_request(input logic awake, input logic sel);
        case ({awake, sel})
            2'b11:   return M_NORM;
            2'b10:   return M_SILENT;
            2'b01:   return M_GTS;
            default: return M_STBY;
        endcase
    endfunction

    function automatic logic drives_inh(input mode_e m);
        return (m != M_OFF) && (m != M_SLEEP);
    endfunction

endpackage

// File: rtl/uv_filter.sv
module uv_filter #(
    parameter int DET_TICKS = 200,
    parameter int REC_TICKS = 800
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic raw_low,
    output logic flag,
    output logic set_now
);
    localparam int MAXT = (DET_TICKS > REC_TICKS) ? DET_TICKS : REC_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] DET_LAST = CW'(DET_TICKS - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          against;   // raw level disagrees with flag
    logic          last;

    assign against = flag ? !raw_low : raw_low;
    assign last    = flag ? (cnt == REC_LAST) : (cnt == DET_LAST);
    assign set_now = !clr && !flag && against && tick && last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag <= 1'b0;
            cnt  <= '0;
        end else if (!against) begin
            cnt <= '0;
        end else if (tick) begin
            if (last) begin
                flag <= !flag;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gts_hold.sv
module gts_hold #(
    parameter int HOLD_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HMAX = HW'(HOLD_TICKS);

    logic [HW-1:0] cnt;

    assign done = (cnt == HMAX);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick && !done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int HOLD_TICKS = 10,
    parameter int DET_TICKS  = 200,
    parameter int REC_TICKS  = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ctl_awake,
    input  logic       ctl_sel,
    input  logic       batt_low,
    input  logic       core_low,
    input  logic       io_low,
    input  logic       wake_seen,
    output logic [2:0] mode,
    output logic       inh_on,
    output logic       por_flag,
    output logic       wake_clr,
    output logic       silent_from_norm
);
    mode_e mode_q, nxt;
    logic  host_sleep_q, host_sleep_n;
    logic  awake_q, wake_q;
    logic  awake_rise, wake_rise;
    logic  hold_done, uv_clr, uv_any;
    logic [NUM_SUPPLY-1:0] raw_low, uv_flag, uv_set;

    assign raw_low[SUP_CORE] = core_low;
    assign raw_low[SUP_IO]   = io_low;
    assign awake_rise = ctl_awake && !awake_q;
    assign wake_rise  = wake_seen && !wake_q;
    assign uv_any     = |uv_flag;
    assign uv_clr     = wake_rise || (mode_q == M_OFF) ||
                        ((mode_q == M_SLEEP) && awake_rise);

    for (genvar s = 0; s < NUM_SUPPLY; s++) begin : g_sup
        uv_filter #(.DET_TICKS(DET_TICKS), .REC_TICKS(REC_TICKS)) u_filt (
            .clk(clk), .rst(rst || batt_low), .clr(uv_clr), .tick(tick),
            .raw_low(raw_low[s]), .flag(uv_flag[s]), .set_now(uv_set[s])
        );
    end

    gts_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst(rst || batt_low), .run(mode_q == M_GTS),
        .tick(tick), .done(hold_done)
    );

    always_comb begin
        mode_e req;
        req          = pin_request(ctl_awake, ctl_sel);
        nxt          = mode_q;
        host_sleep_n = host_sleep_q;
        case (mode_q)
            M_OFF: nxt = M_STBY;
            M_STBY, M_NORM, M_SILENT, M_GTS: begin
                if (uv_any) begin
                    nxt          = M_SLEEP;
                    host_sleep_n = 1'b0;
                end else if (mode_q == M_GTS && req == M_GTS &&
                             hold_done && !wake_seen) begin
                    nxt          = M_SLEEP;
                    host_sleep_n = 1'b1;
                end else begin
                    nxt = req;
                end
            end
            M_SLEEP: begin
                if (wake_seen)
                    nxt = M_STBY;
                else if (awake_rise && !uv_flag[SUP_IO])
                    nxt = ctl_sel ? M_NORM : M_SILENT;
                else if (!host_sleep_q && !uv_any)
                    nxt = M_STBY;
            end
            default: nxt = M_OFF;
        endcase
        if (batt_low) nxt = M_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst || batt_low) begin
            mode_q           <= M_OFF;
            host_sleep_q     <= 1'b0;
            inh_on           <= 1'b0;
            por_flag         <= 1'b0;
            wake_clr         <= 1'b0;
            silent_from_norm <= 1'b0;
            awake_q          <= 1'b0;
            wake_q           <= 1'b0;
        end else begin
            mode_q       <= nxt;
            host_sleep_q <= host_sleep_n;
            inh_on       <= drives_inh(nxt);
            awake_q      <= ctl_awake;
            wake_q       <= wake_seen;
            wake_clr     <= ((nxt == M_NORM) && (mode_q != M_NORM)) || (|uv_set);
            if (mode_q == M_OFF)
                por_flag <= 1'b1;
            else if (nxt == M_NORM)
                por_flag <= 1'b0;
            if (nxt != M_SILENT)
                silent_from_norm <= 1'b0;
            else if (mode_q != M_SILENT)
                silent_from_norm <= (mode_q == M_NORM);
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk
    import xcvr_mode_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       batt_low,
    input logic [2:0] mode,
    input logic       inh_on,
    input logic       por_flag,
    input logic       wake_clr,
    input logic       silent_from_norm
);
    a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
        mode <= 3'd5);

    a_r2_batt_to_off: assert property (@(posedge clk) disable iff (rst)
        batt_low |=> (mode == M_OFF && !por_flag && !inh_on));

    a_r3_powerup_standby: assert property (@(posedge clk) disable iff (rst)
        (mode == M_OFF && !batt_low) |=> (mode == M_STBY && por_flag));

    a_r11_inh_follows_mode: assert property (@(posedge clk) disable iff (rst)
        inh_on == (mode != M_OFF && mode != M_SLEEP));

    a_r12_normal_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == M_NORM && $past(mode) != M_NORM) |-> (wake_clr && !por_flag));

    a_r13_origin_only_silent: assert property (@(posedge clk) disable iff (rst)
        silent_from_norm |-> (mode == M_SILENT && $past(mode) inside {M_NORM, M_SILENT}));
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .batt_low(batt_low), .mode(mode), .inh_on(inh_on),
    .por_flag(por_flag), .wake_clr(wake_clr), .silent_from_norm(silent_from_norm)
);

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
    localparam int HOLD = 5;
    localparam int DET  = 8;
    localparam int REC  = 12;
    localparam logic [2:0] OFF = 0, STBY = 1, NORM = 2, SIL = 3, GTS = 4, SLP = 5;

    logic clk = 0, rst = 1, tick = 0, ctl_awake = 0, ctl_sel = 0;
    logic batt_low = 1, core_low = 0, io_low = 0, wake_seen = 0;
    logic [2:0] mode;
    logic inh_on, por_flag, wake_clr, silent_from_norm;
    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xcvr_mode_ctrl #(.HOLD_TICKS(HOLD), .DET_TICKS(DET), .REC_TICKS(REC)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .ctl_awake(ctl_awake), .ctl_sel(ctl_sel),
        .batt_low(batt_low), .core_low(core_low), .io_low(io_low), .wake_seen(wake_seen),
        .mode(mode), .inh_on(inh_on), .por_flag(por_flag), .wake_clr(wake_clr),
        .silent_from_norm(silent_from_norm)
    );

    function automatic logic [2:0] exp_req(input logic a, input logic s);
        return a ? (s ? NORM : SIL) : (s ? GTS : STBY);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; step();
            tick = 0; step();
        end
    endtask

    task automatic pins(input logic a, input logic s);
        ctl_awake = a; ctl_sel = s; step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [2:0] prev, e;
        logic sfn_e;
        void'($urandom(32'd1234));
        @(negedge clk);
        step(); step();
        chk("R2 reset mode", mode, OFF);
        chk("R2 reset inh", inh_on, 0);
        chk("R2 reset por", por_flag, 0);
        rst = 0; step();
        chk("R2 batt low holds off", mode, OFF);
        batt_low = 0; step();
        chk("R3 standby after power-up", mode, STBY);
        chk("R3 por set", por_flag, 1);
        chk("R11 inh in standby", inh_on, 1);

        pins(1, 1);
        chk("R1 normal", mode, NORM);
        chk("R12 wake_clr on normal entry", wake_clr, 1);
        chk("R12 por cleared", por_flag, 0);
        step();
        chk("R12 wake_clr one clock", wake_clr, 0);
        pins(1, 0);
        chk("R1 silent", mode, SIL);
        chk("R13 silent from normal", silent_from_norm, 1);
        pins(0, 0);
        pins(1, 0);
        chk("R13 silent from standby", silent_from_norm, 0);

        // R1 / R13 random pin patterns
        prev = mode; sfn_e = 0;
        for (int i = 0; i < 200; i++) begin
            logic a, s;
            a = 1'($urandom); s = 1'($urandom);
            pins(a, s);
            e = exp_req(a, s);
            if (e == SIL) sfn_e = (prev == SIL) ? sfn_e : (prev == NORM);
            else sfn_e = 0;
            chk("R1 random decode", mode, e);
            chk("R13 random origin", silent_from_norm, sfn_e);
            chk("R12 random wake_clr", wake_clr, (e == NORM && prev != NORM));
            prev = e;
        end

        // R4 go-to-sleep timing and interruption
        pins(0, 0);
        pins(0, 1);
        chk("R1 go-to-sleep", mode, GTS);
        ticks(HOLD - 1);
        chk("R4 not yet sleep", mode, GTS);
        pins(0, 0);
        chk("R4 interrupted follows request", mode, STBY);
        pins(0, 1);
        ticks(HOLD);
        chk("R4 sleep after hold", mode, SLP);
        chk("R11 inh off in sleep", inh_on, 0);

        // R8 host sleep ignores supply fault and recovery
        core_low = 1; ticks(DET);
        core_low = 0; ticks(REC + 2);
        chk("R8 host sleep kept", mode, SLP);

        // R10 edge blocked with io flag set, then allowed
        io_low = 1; ticks(DET);
        pins(1, 1);
        chk("R10 edge blocked by io flag", mode, SLP);
        io_low = 0;
        pins(0, 1);
        chk("R10 no edge stays sleep", mode, SLP);
        pins(1, 1);
        chk("R10 edge to normal", mode, NORM);

        // R6 detect count, gap restart, forced sleep, wake_clr on set
        core_low = 1; ticks(DET - 1);
        core_low = 0; ticks(1);
        core_low = 1; ticks(DET - 1);
        chk("R6 gap restarts count", mode, NORM);
        tick = 1; step(); tick = 0;
        chk("R12 wake_clr on flag set", wake_clr, 1);
        chk("R6 one clock before sleep", mode, NORM);
        step();
        chk("R6 forced sleep", mode, SLP);

        // R7 forced sleep leaves on recovery
        core_low = 0; ticks(REC - 1);
        chk("R7 still sleeping", mode, SLP);
        ticks(1);
        chk("R7 recovery to standby", mode, STBY);
        step();
        chk("R1 normal after recovery", mode, NORM);

        // R9 wake leaves forced sleep
        core_low = 1; ticks(DET);
        chk("R6 forced sleep again", mode, SLP);
        wake_seen = 1; step();
        chk("R9 wake to standby", mode, STBY);
        wake_seen = 0; core_low = 0;
        ctl_awake = 0; ctl_sel = 0; step();

        // R14 wake edge restarts undervoltage count
        core_low = 1; ticks(DET - 2);
        wake_seen = 1; step();
        wake_seen = 0; step();
        ticks(DET - 2);
        chk("R14 count restarted by wake", mode, STBY);
        ticks(2);
        chk("R14 sleep after full count", mode, SLP);
        core_low = 0; ticks(REC);
        chk("R7 back to standby", mode, STBY);

        // R5 wake blocks go-to-sleep
        wake_seen = 1;
        pins(0, 1);
        ticks(HOLD + 2);
        chk("R5 wake blocks sleep", mode, GTS);
        wake_seen = 0; step();
        chk("R4 sleep once wake clears", mode, SLP);
        pins(1, 0);
        chk("R10 edge to silent", mode, SIL);
        chk("R13 silent from sleep", silent_from_norm, 0);

        // R2 battery priority from normal
        pins(1, 1);
        batt_low = 1; core_low = 1; step();
        chk("R2 battery to off", mode, OFF);
        chk("R2 por cleared in off", por_flag, 0);
        chk("R11 inh off in off", inh_on, 0);
        batt_low = 0; core_low = 0; ctl_awake = 0; ctl_sel = 0; step();
        chk("R3 standby again", mode, STBY);
        chk("R3 por again", por_flag, 1);

        finish_run();
    end
endmodule